// File: doc/BRIEF.md
# Asynchronous Memory Strobe Sequencer

This block runs single read and write accesses to an external asynchronous device such as an SRAM or a NOR flash. A host raises a request with address, byte-lane selection, direction and write data. The block keeps the request until it has finished the external access, then returns a one-clock acknowledge with the read data and an error flag. Every access has three phases: setup, strobe and hold. The length of each phase, in clocks, comes from configuration inputs. Reads and writes have separate settings. After each access, the block waits a programmable number of clocks before it accepts the next request.

The strobe can be stretched by an external wait pin. The pin passes through a two-stage synchronizer, and a configuration bit sets its active level. The stretch is capped by a programmable limit. If the limit is reached, the access ends with an error and a sticky timeout status is set. A select-strobe option makes chip select follow the strobe instead of covering the whole access. The block samples all configuration values when it accepts a request, so changing them in the middle of an access has no effect on that access.

Top module: `amem_strobe_ctrl`

## Requirements
- R1: While reset is held and after it is released, chip select, output enable and write enable are high, data drive enable is low, the acknowledge and error outputs are low, and the sticky timeout status is low.
- R2: A read accepted in the idle state starts setup on the next clock. Each read phase lasts its field value plus one clocks: setup field 4 bits, strobe field 6 bits, hold field 3 bits. Output enable is low exactly during the strobe phase, and write enable stays high.
- R3: A write uses its own three fields, with the same widths and the same plus-one coding. Write enable is low exactly during the strobe phase. Data drive enable is high and the data outputs hold the request's write data from the start of setup to the end of hold.
- R4: After hold ends, chip select stays high for the turnaround field plus one clocks (2-bit field). The block then spends one idle clock before it can start the next setup, even if a new request is already pending.
- R5: With wait mode on, the wait input is checked in the last programmed strobe clock. If the synchronized wait is active in that clock, the strobe continues. Output enable or write enable then rises on the fourth rising clock edge after the wait pin goes inactive. If the wait pin went inactive early enough, or wait mode is off, the strobe is not extended.
- R6: If the wait input stays active for the cap (8-bit field plus one clocks) after the programmed strobe, the strobe ends and the full hold phase runs. The acknowledge then comes with the error flag high, and the sticky timeout status goes high and stays high until reset. If the wait input goes inactive in the last clock of the cap, the access ends without an error.
- R7: In normal mode, chip select is low from the first setup clock to the last hold clock. In select-strobe mode, chip select is low only while the strobe is low.
- R8: Address, bank and direction outputs (high means read) hold the accepted request's values from the first setup clock to the last hold clock.
- R9: Read data is captured on the clock edge that ends the strobe and is returned together with the acknowledge.
- R10: The acknowledge is high for exactly one clock, the clock that follows the last hold clock.
- R11: Configuration changes made after a request is accepted do not affect that access.
- R12: A wait polarity bit of 1 makes a high wait pin active. A value of 0 makes a low wait pin active.
- R13: Output enable and write enable are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request pending, held until acknowledge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_bank | input | BANK_W | Request bank / byte-lane bits |
| req_wdata | input | DATA_W | Write data |
| rsp_ack | output | 1 | One-clock completion pulse |
| rsp_err | output | 1 | Access ended by wait timeout (valid with acknowledge) |
| rsp_rdata | output | DATA_W | Captured read data (valid with acknowledge) |
| cfg_rd_setup | input | SETUP_W | Read setup clocks minus one |
| cfg_rd_strobe | input | STROBE_W | Read strobe clocks minus one |
| cfg_rd_hold | input | HOLD_W | Read hold clocks minus one |
| cfg_wr_setup | input | SETUP_W | Write setup clocks minus one |
| cfg_wr_strobe | input | STROBE_W | Write strobe clocks minus one |
| cfg_wr_hold | input | HOLD_W | Write hold clocks minus one |
| cfg_turn | input | TURN_W | Turnaround clocks minus one |
| cfg_wait_max | input | MWAIT_W | Wait cap clocks minus one |
| cfg_wait_en | input | 1 | Enable strobe stretching by the wait pin |
| cfg_sel_strobe | input | 1 | Chip select follows the strobe |
| cfg_wait_pol | input | 1 | Active level of the wait pin |
| timeout_seen | output | 1 | Sticky: some access has timed out |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_bank | output | BANK_W | Bank / byte-lane outputs |
| mem_rnw | output | 1 | Direction: 1 = read |
| mem_dq_o | output | DATA_W | Write data to the device |
| mem_dq_oe | output | 1 | Data drive enable |
| mem_dq_i | input | DATA_W | Read data from the device |
| mem_wait | input | 1 | Wait pin from the device |

## Verification
The sequence mixes reads and writes whose three phase lengths differ from each other and from the unused direction's settings, so selecting the wrong field or adding one clock to any phase changes the waveform. Wait tests cover release before the strobe ends (no stretch), release in the middle of the window (4-edge release delay), release in the last clock of the cap (no error), a pin stuck active (timeout and sticky status), a pin active while wait mode is off (ignored), and an inverted polarity. Other accesses use select-strobe mode, the minimum and maximum field values, and configuration that is scrambled in the middle of an access. Each new request is presented during the turnaround, so a shortened gap or an early accept shifts every following access.

// File: rtl/amem_pkg.sv
package amem_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_WAIT   = 3'd3,
    PH_WEND   = 3'd4,
    PH_HOLD   = 3'd5,
    PH_TURN   = 3'd6
  } phase_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/amem_wait_sync.sv
module amem_wait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic pol,
  output logic active
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign active = (sync_q[STAGES-1] == pol);
endmodule

// File: rtl/amem_phase_timer.sv
module amem_phase_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/amem_pin_decode.sv
module amem_pin_decode
  import amem_pkg::*;
(
  input  phase_e ph,
  input  logic   is_write,
  input  logic   sel_strobe,
  output logic   cs_n,
  output logic   oe_n,
  output logic   we_n,
  output logic   dq_oe
);
  logic in_strobe;
  logic in_access;

  always_comb begin
    in_strobe = (ph == PH_STROBE) || (ph == PH_WAIT) || (ph == PH_WEND);
    in_access = in_strobe || (ph == PH_SETUP) || (ph == PH_HOLD);
    cs_n      = sel_strobe ? !in_strobe : !in_access;
    oe_n      = !(in_strobe && !is_write);
    we_n      = !(in_strobe && is_write);
    dq_oe     = in_access && is_write;
  end
endmodule

// File: rtl/amem_strobe_ctrl.sv
module amem_strobe_ctrl
  import amem_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int BANK_W   = 2,
  parameter int DATA_W   = 16,
  parameter int SETUP_W  = 4,
  parameter int STROBE_W = 6,
  parameter int HOLD_W   = 3,
  parameter int TURN_W   = 2,
  parameter int MWAIT_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [BANK_W-1:0]   req_bank,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_ack,
  output logic                rsp_err,
  output logic [DATA_W-1:0]   rsp_rdata,
  input  logic [SETUP_W-1:0]  cfg_rd_setup,
  input  logic [STROBE_W-1:0] cfg_rd_strobe,
  input  logic [HOLD_W-1:0]   cfg_rd_hold,
  input  logic [SETUP_W-1:0]  cfg_wr_setup,
  input  logic [STROBE_W-1:0] cfg_wr_strobe,
  input  logic [HOLD_W-1:0]   cfg_wr_hold,
  input  logic [TURN_W-1:0]   cfg_turn,
  input  logic [MWAIT_W-1:0]  cfg_wait_max,
  input  logic                cfg_wait_en,
  input  logic                cfg_sel_strobe,
  input  logic                cfg_wait_pol,
  output logic                timeout_seen,
  output logic                mem_cs_n,
  output logic                mem_oe_n,
  output logic                mem_we_n,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [BANK_W-1:0]   mem_bank,
  output logic                mem_rnw,
  output logic [DATA_W-1:0]   mem_dq_o,
  output logic                mem_dq_oe,
  input  logic [DATA_W-1:0]   mem_dq_i,
  input  logic                mem_wait
);
  localparam int CNT_W = max2(max2(max2(SETUP_W, STROBE_W), max2(HOLD_W, TURN_W)), MWAIT_W);

  phase_e ph_q, ph_d;

  // request and timing captured at accept
  logic [ADDR_W-1:0]   addr_q;
  logic [BANK_W-1:0]   bank_q;
  logic [DATA_W-1:0]   wdata_q;
  logic                write_q;
  logic [STROBE_W-1:0] strobe_q;
  logic [HOLD_W-1:0]   hold_q;
  logic [TURN_W-1:0]   turn_q;
  logic [MWAIT_W-1:0]  mwait_q;
  logic                wen_q;
  logic                sel_q;
  logic                pol_q;

  logic [DATA_W-1:0]   rdata_q;
  logic                ack_q;
  logic                err_q;
  logic                to_cur_q;
  logic                sticky_q;

  logic                accept;
  logic                capture;
  logic                to_evt;
  logic                done;
  logic                tload;
  logic [CNT_W-1:0]    tval;
  logic                tzero;
  logic                wait_act;

  amem_wait_sync #(.STAGES(2)) u_wsync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin    (mem_wait),
    .pol    (pol_q),
    .active (wait_act)
  );

  amem_phase_timer #(.W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tload),
    .load_val (tval),
    .zero     (tzero)
  );

  amem_pin_decode u_pins (
    .ph         (ph_q),
    .is_write   (write_q),
    .sel_strobe (sel_q),
    .cs_n       (mem_cs_n),
    .oe_n       (mem_oe_n),
    .we_n       (mem_we_n),
    .dq_oe      (mem_dq_oe)
  );

  // next-state logic
  always_comb begin
    ph_d    = ph_q;
    tload   = 1'b0;
    tval    = '0;
    accept  = 1'b0;
    capture = 1'b0;
    to_evt  = 1'b0;
    done    = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          tload  = 1'b1;
          tval   = req_write ? CNT_W'(cfg_wr_setup) : CNT_W'(cfg_rd_setup);
          ph_d   = PH_SETUP;
        end
      end
      PH_SETUP: begin
        if (tzero) begin
          tload = 1'b1;
          tval  = CNT_W'(strobe_q);
          ph_d  = PH_STROBE;
        end
      end
      PH_STROBE: begin
        if (tzero) begin
          tload = 1'b1;
          if (wen_q && wait_act) begin
            tval = CNT_W'(mwait_q);
            ph_d = PH_WAIT;
          end else begin
            tval    = CNT_W'(hold_q);
            capture = 1'b1;
            ph_d    = PH_HOLD;
          end
        end
      end
      PH_WAIT: begin
        if (!wait_act) begin
          ph_d = PH_WEND;
        end else if (tzero) begin
          tload   = 1'b1;
          tval    = CNT_W'(hold_q);
          capture = 1'b1;
          to_evt  = 1'b1;
          ph_d    = PH_HOLD;
        end
      end
      PH_WEND: begin
        tload   = 1'b1;
        tval    = CNT_W'(hold_q);
        capture = 1'b1;
        ph_d    = PH_HOLD;
      end
      PH_HOLD: begin
        if (tzero) begin
          tload = 1'b1;
          tval  = CNT_W'(turn_q);
          done  = 1'b1;
          ph_d  = PH_TURN;
        end
      end
      PH_TURN: begin
        if (tzero) ph_d = PH_IDLE;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  // request capture, enabled by accept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      bank_q   <= '0;
      wdata_q  <= '0;
      write_q  <= 1'b0;
      strobe_q <= '0;
      hold_q   <= '0;
      turn_q   <= '0;
      mwait_q  <= '0;
      wen_q    <= 1'b0;
      sel_q    <= 1'b0;
      pol_q    <= 1'b1;
    end else if (accept) begin
      addr_q   <= req_addr;
      bank_q   <= req_bank;
      wdata_q  <= req_wdata;
      write_q  <= req_write;
      strobe_q <= req_write ? cfg_wr_strobe : cfg_rd_strobe;
      hold_q   <= req_write ? cfg_wr_hold : cfg_rd_hold;
      turn_q   <= cfg_turn;
      mwait_q  <= cfg_wait_max;
      wen_q    <= cfg_wait_en;
      sel_q    <= cfg_sel_strobe;
      pol_q    <= cfg_wait_pol;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= mem_dq_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q    <= 1'b0;
      err_q    <= 1'b0;
      to_cur_q <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      ack_q <= done;
      err_q <= done && to_cur_q;
      if (accept)      to_cur_q <= 1'b0;
      else if (to_evt) to_cur_q <= 1'b1;
      if (to_evt)      sticky_q <= 1'b1;
    end
  end

  assign rsp_ack      = ack_q;
  assign rsp_err      = err_q;
  assign rsp_rdata    = rdata_q;
  assign timeout_seen = sticky_q;
  assign mem_addr     = addr_q;
  assign mem_bank     = bank_q;
  assign mem_rnw      = !write_q;
  assign mem_dq_o     = wdata_q;

  // ---------------- assertions ----------------
  assert_strobe_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  assert_cs_covers_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> !mem_cs_n);

  assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |=> !rsp_ack);

  assert_err_with_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_ack);

  assert_sticky_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_seen |=> timeout_seen);

  assert_addr_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_bank) && $stable(mem_rnw)));

  assert_ack_after_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |-> (mem_oe_n && mem_we_n && !mem_dq_oe));
endmodule

// File: tb/sim_amem_strobe_ctrl.sv
module sim_amem_strobe_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [15:0] req_addr, req_wdata;
  logic [1:0]  req_bank;
  logic        rsp_ack, rsp_err;
  logic [15:0] rsp_rdata;
  logic [3:0]  cfg_rd_setup, cfg_wr_setup;
  logic [5:0]  cfg_rd_strobe, cfg_wr_strobe;
  logic [2:0]  cfg_rd_hold, cfg_wr_hold;
  logic [1:0]  cfg_turn;
  logic [7:0]  cfg_wait_max;
  logic        cfg_wait_en, cfg_sel_strobe, cfg_wait_pol;
  logic        timeout_seen;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_rnw, mem_dq_oe;
  logic [15:0] mem_addr, mem_dq_o, mem_dq_i;
  logic [1:0]  mem_bank;
  logic        mem_wait;

  always #5 clk = ~clk;

  amem_strobe_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_bank(req_bank), .req_wdata(req_wdata),
    .rsp_ack(rsp_ack), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .cfg_rd_setup(cfg_rd_setup), .cfg_rd_strobe(cfg_rd_strobe), .cfg_rd_hold(cfg_rd_hold),
    .cfg_wr_setup(cfg_wr_setup), .cfg_wr_strobe(cfg_wr_strobe), .cfg_wr_hold(cfg_wr_hold),
    .cfg_turn(cfg_turn), .cfg_wait_max(cfg_wait_max), .cfg_wait_en(cfg_wait_en),
    .cfg_sel_strobe(cfg_sel_strobe), .cfg_wait_pol(cfg_wait_pol),
    .timeout_seen(timeout_seen),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_bank(mem_bank), .mem_rnw(mem_rnw),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i), .mem_wait(mem_wait)
  );

  typedef struct {
    bit wr; int addr; int ba; int wd; int rd;
    int sf; int tf; int hf; int ta; int mw;
    bit ext; bit sel; bit pol; bit wact; bit scr; int rel;
  } txn_t;

  localparam int NT = 12;
  txn_t tl [NT];
  int   total = 0;
  int   bad   = 0;
  bit   finished = 0;
  bit   to_so_far = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic txn_t mk(bit wr, int addr, int ba, int wd, int rd, int sf, int tf, int hf,
                              int ta, int mw, bit ext, bit sel, bit pol, bit wact, bit scr, int rel);
    txn_t t;
    t.wr = wr; t.addr = addr; t.ba = ba; t.wd = wd; t.rd = rd;
    t.sf = sf; t.tf = tf; t.hf = hf; t.ta = ta; t.mw = mw;
    t.ext = ext; t.sel = sel; t.pol = pol; t.wact = wact; t.scr = scr; t.rel = rel;
    return t;
  endfunction

  task automatic apply_cfg(input txn_t t);
    // the unused direction gets distinct lengths so a wrong pick shows up
    cfg_rd_setup  = t.wr ? 4'd5 : 4'(t.sf);
    cfg_rd_strobe = t.wr ? 6'd5 : 6'(t.tf);
    cfg_rd_hold   = t.wr ? 3'd5 : 3'(t.hf);
    cfg_wr_setup  = t.wr ? 4'(t.sf) : 4'd6;
    cfg_wr_strobe = t.wr ? 6'(t.tf) : 6'd6;
    cfg_wr_hold   = t.wr ? 3'(t.hf) : 3'd6;
    cfg_turn      = 2'(t.ta);
    cfg_wait_max  = 8'(t.mw);
    cfg_wait_en   = t.ext;
    cfg_sel_strobe = t.sel;
    cfg_wait_pol  = t.pol;
    mem_wait      = t.wact ? t.pol : !t.pol;
    mem_dq_i      = 16'(t.rd);
  endtask

  task automatic present(input txn_t t);
    req_valid = 1'b1;
    req_write = t.wr;
    req_addr  = 16'(t.addr);
    req_bank  = 2'(t.ba);
    req_wdata = 16'(t.wd);
  endtask

  task automatic scramble();
    cfg_rd_setup = 4'd0; cfg_rd_strobe = 6'd0; cfg_rd_hold = 3'd0;
    cfg_wr_setup = 4'd0; cfg_wr_strobe = 6'd0; cfg_wr_hold = 3'd0;
    cfg_turn = 2'd0; cfg_wait_max = 8'd0;
    cfg_wait_en = !cfg_wait_en; cfg_sel_strobe = !cfg_sel_strobe;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    //            wr addr    ba wd      rd      sf tf hf ta mw ext sel pol wact scr rel
    tl[0]  = mk(0, 'h1234, 1, 'h0000, 'hA5C3, 1, 2, 1, 1, 0, 0, 0, 1, 0, 0, -1);
    tl[1]  = mk(1, 'h0F0F, 2, 'hBEEF, 'h0000, 2, 3, 0, 0, 0, 0, 0, 1, 0, 0, -1);
    tl[2]  = mk(0, 'h2222, 3, 'h0000, 'h5A5A, 3, 1, 2, 3, 0, 0, 1, 1, 0, 0, -1);
    tl[3]  = mk(1, 'h3333, 0, 'hC0DE, 'h0000, 1, 2, 2, 2, 0, 0, 1, 1, 0, 0, -1);
    tl[4]  = mk(0, 'h4444, 1, 'h0000, 'h1357, 1, 1, 1, 0, 15, 1, 0, 1, 1, 0, 8);
    tl[5]  = mk(0, 'h5555, 2, 'h0000, 'h2468, 1, 1, 0, 1, 15, 1, 0, 1, 1, 0, 0);
    tl[6]  = mk(1, 'h6666, 3, 'hFACE, 'h0000, 0, 1, 1, 1, 3, 1, 0, 1, 1, 0, 1000);
    tl[7]  = mk(0, 'h7777, 0, 'h0000, 'h9999, 1, 2, 0, 0, 2, 0, 0, 1, 1, 0, 1000);
    tl[8]  = mk(0, 'h8888, 1, 'h0000, 'h7E7E, 0, 0, 1, 2, 20, 1, 0, 0, 1, 0, 6);
    tl[9]  = mk(0, 'h9999, 2, 'h0000, 'hD00D, 15, 63, 7, 3, 0, 0, 0, 1, 0, 1, -1);
    tl[10] = mk(1, 'hAAAA, 3, 'h1111, 'h0000, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, -1);
    tl[11] = mk(1, 'hBBBB, 0, 'h2222, 'h0000, 0, 0, 1, 1, 1, 1, 0, 1, 1, 0, 1);

    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_bank = '0; req_wdata = '0;
    apply_cfg(tl[0]);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs during reset
    chk(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_ack && !rsp_err && !timeout_seen,
        "R1", "reset outputs", {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_ack, timeout_seen}, 'b111000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_ack && !timeout_seen,
        "R1", "after reset", {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, rsp_ack, timeout_seen}, 'b111000);

    present(tl[0]);
    @(negedge clk);

    for (int k = 0; k < NT; k++) begin
      txn_t t;
      int s, tt, h, m, x, lend, hend, last;
      bit to;
      string lab_s, lab_cs;
      t = tl[k];
      s = t.sf + 1; tt = t.tf + 1; h = t.hf + 1; m = t.mw + 1;
      to = 1'b0; x = 0;
      if (t.ext && t.wact) begin
        if (t.rel + 2 <= s + tt - 1)          x = 0;
        else if (t.rel + 2 <= s + tt + m - 1) x = t.rel + 4 - s - tt;
        else begin x = m; to = 1'b1; end
      end
      lend = s + tt + x;
      hend = lend + h;
      last = hend + t.ta + 1;
      lab_s  = t.scr ? "R11" : (t.ext ? (to ? "R6" : "R5") : (t.wact ? "R5" : (t.wr ? "R3" : "R2")));
      if (!t.pol) lab_s = "R12";
      lab_cs = t.sel ? "R7" : lab_s;

      for (int i = 0; i <= last; i++) begin
        bit strb, acc, exp_to;
        strb = (i >= s) && (i < lend);
        acc  = (i < hend);
        exp_to = to_so_far || (to && i >= lend);
        if (i > hend) begin
          chk(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R4", "gap pins",
              {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe}, 'b1110);
        end else begin
          chk(mem_cs_n == (t.sel ? !strb : !acc), lab_cs, "cs_n", mem_cs_n, t.sel ? !strb : !acc);
          chk(mem_oe_n == !(strb && !t.wr), lab_s, "oe_n", mem_oe_n, !(strb && !t.wr));
          chk(mem_we_n == !(strb && t.wr), t.wr ? "R3" : lab_s, "we_n", mem_we_n, !(strb && t.wr));
          chk(mem_dq_oe == (acc && t.wr), "R3", "dq_oe", mem_dq_oe, acc && t.wr);
        end
        chk(!(!mem_oe_n && !mem_we_n), "R13", "oe/we overlap", {mem_oe_n, mem_we_n}, 'b11);
        chk(rsp_ack == (i == hend), "R10", "ack", rsp_ack, i == hend);
        chk(rsp_err == (to && i == hend), "R6", "err", rsp_err, to && i == hend);
        chk(timeout_seen == exp_to, "R6", "sticky timeout", timeout_seen, exp_to);
        if (acc) begin
          chk(mem_addr == 16'(t.addr), "R8", "addr", mem_addr, t.addr);
          chk(mem_bank == 2'(t.ba), "R8", "bank", mem_bank, t.ba);
          chk(mem_rnw == !t.wr, "R8", "rnw", mem_rnw, !t.wr);
          if (t.wr) chk(mem_dq_o == 16'(t.wd), "R3", "dq_o", mem_dq_o, t.wd);
        end
        if (i == hend && !t.wr)
          chk(rsp_rdata == 16'(t.rd), "R9", "rdata", rsp_rdata, t.rd);

        // drive actions within cycle i
        if (t.wact && i == t.rel) mem_wait = !t.pol;
        if (i == lend) mem_dq_i = ~16'(t.rd);
        if (t.scr && i == 1) scramble();
        if (i == hend) begin
          if (k + 1 < NT) present(tl[k+1]);
          else req_valid = 1'b0;
        end
        if (i == last) begin
          if (to) to_so_far = 1'b1;
          if (k + 1 < NT) apply_cfg(tl[k+1]);
        end
        @(negedge clk);
      end
    end

    repeat (3) @(negedge clk);
    chk(mem_cs_n && !rsp_ack && timeout_seen, "R6", "final idle, sticky kept",
        {mem_cs_n, rsp_ack, timeout_seen}, 'b101);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule